// File: doc/BRIEF.md
# Dual Programmable Timer/Counter

This peripheral holds two independent timer channels, each with a control word, a reload value and a live counter. A processor reaches the channels over a simple register bus. The bus takes an address, a write strobe and write data on one clock edge, and read data follows the address combinationally.

Each channel counts up or down by one on every clock while it runs. When it passes its terminal value it latches a sticky pending flag. It then either reloads from its reload register, which gives a periodic tick or a free-running time base, or it stops where it is.

A level interrupt output combines the pending flags of the channels whose interrupt enable is set. Three control bits (capture select, output-generate enable and pulse-width enable) are only stored and read back.

Top module: `tmr_dual`

## Requirements
- R1: After reset every control word, reload register and counter reads zero, and `irq` is low.
- R2: Byte addresses pick the registers. Address bit 4 picks the channel. Address bits 3:2 pick control (0), reload (1) or counter (2). Selector 3 reads zero. Writes to the counter are ignored.
- R3: Control bits 0–7, 9 and 10 read back exactly as last written. Bits 11 to 31 always read zero.
- R4: Bit 8 is the pending flag. Writing 1 to it clears it and writing 0 leaves it alone, so writing back a value just read acknowledges an event without changing the other bits.
- R5: While bit 5 (load) is 1, the counter takes the reload value on every clock. It starts counting from that value only after bit 5 is written back to 0.
- R6: While bit 7 (run) is 1 and load is 0, the counter moves by one per clock: down when bit 1 is 1, up when it is 0. With run at 0 the counter holds its value.
- R7: When counting down from 0 with bit 4 (auto-reload) set, the next clock sets the pending flag and loads the reload value. Counting then goes on.
- R8: When counting up from all-ones with auto-reload set, the next clock sets the pending flag and loads the reload value. With a reload value of 0 the counter wraps modulo 2^32.
- R9: With auto-reload clear, the expiring clock sets the pending flag, keeps the counter at its terminal value and clears the run bit.
- R10: `irq` is high exactly when some channel has both its pending flag and bit 6 (interrupt enable) set.
- R11: A control write with bit 10 set, to either channel, sets the run bit of both channels on that clock.
- R12: If an expiry and a write-one-to-clear of the pending flag fall on the same clock, the flag stays set.
- R13: Bits 0, 2, 3 and 9 change neither counting nor expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 5 | Byte address of the register |
| busWrEn | input | 1 | Write strobe, one clock per write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr` (combinational) |
| irq | output | 1 | Level interrupt request |

## Verification
The properties assume a write strobe lasts one clock and carries a word-aligned address inside the map. The bench drives only offsets 0x00–0x1C, with the low two address bits at zero. The hold and sticky-flag properties need a clock with no bus write, because a write in the same clock may legally override them. The random mix keeps many idle and read clocks for that reason. It sets the load bit rarely, so that terminal crossings are often reached, and it biases reload values toward 0, 1 and all-ones so that expiries happen within a few clocks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CTRL_BITS = 11;
  localparam int B_MODE = 0;
  localparam int B_DOWN = 1;
  localparam int B_GEN  = 2;
  localparam int B_CAPT = 3;
  localparam int B_AUTO = 4;
  localparam int B_LOAD = 5;
  localparam int B_IE   = 6;
  localparam int B_RUN  = 7;
  localparam int B_PEND = 8;
  localparam int B_PWM  = 9;
  localparam int B_ALL  = 10;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_LOAD  = 2'd1,
    SEL_COUNT = 2'd2,
    SEL_NONE  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic ctrlWr;
    logic loadWr;
    logic enAll;
  } chanStrobe_t;
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
  import tmr_pkg::*;
#(
  parameter int NUM_TIMERS = 2,
  parameter int DATA_W = 32,
  parameter int TSEL_W = 1,
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output chanStrobe_t       stb [NUM_TIMERS],
  output regSel_e           regSel,
  output logic [TSEL_W-1:0] chanSel,
  output logic              chanValid
);
  logic enAllReq;

  always_comb begin
    regSel    = regSel_e'(busAddr[3:2]);
    chanSel   = busAddr[ADDR_W-1:4];
    chanValid = (int'(chanSel) < NUM_TIMERS);
    enAllReq  = busWrEn && chanValid && (regSel == SEL_CTRL) && busWrData[B_ALL];
  end

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_stb
    logic hit;
    assign hit = busWrEn && (chanSel == TSEL_W'(i));
    assign stb[i].ctrlWr = hit && (regSel == SEL_CTRL);
    assign stb[i].loadWr = hit && (regSel == SEL_LOAD);
    assign stb[i].enAll  = enAllReq;
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  chanStrobe_t          stb,
  input  logic [DATA_W-1:0]    wrData,
  output logic [CTRL_BITS-1:0] ctrlQ,
  output logic [DATA_W-1:0]    loadQ,
  output logic [DATA_W-1:0]    countQ
);
  localparam logic [DATA_W-1:0] UP_TERM = '1;

  logic                 atTerm;
  logic                 expire;
  logic                 holdClr;
  logic [CTRL_BITS-1:0] ctrlNext;
  logic [DATA_W-1:0]    countNext;

  always_comb begin
    atTerm  = ctrlQ[B_DOWN] ? (countQ == '0) : (countQ == UP_TERM);
    expire  = !ctrlQ[B_LOAD] && ctrlQ[B_RUN] && atTerm;
    holdClr = expire && !ctrlQ[B_AUTO];

    if (ctrlQ[B_LOAD])
      countNext = loadQ;
    else if (!ctrlQ[B_RUN])
      countNext = countQ;
    else if (atTerm)
      countNext = ctrlQ[B_AUTO] ? loadQ : countQ;
    else if (ctrlQ[B_DOWN])
      countNext = countQ - 1'b1;
    else
      countNext = countQ + 1'b1;

    ctrlNext = ctrlQ;
    if (stb.ctrlWr) begin
      ctrlNext         = wrData[CTRL_BITS-1:0];
      ctrlNext[B_PEND] = ctrlQ[B_PEND] & ~wrData[B_PEND];
    end else begin
      ctrlNext[B_RUN]  = ctrlQ[B_RUN] & ~holdClr;
    end
    ctrlNext[B_PEND] = ctrlNext[B_PEND] | expire;
    ctrlNext[B_RUN]  = ctrlNext[B_RUN] | stb.enAll;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ  <= '0;
      loadQ  <= '0;
      countQ <= '0;
    end else begin
      ctrlQ  <= ctrlNext;
      countQ <= countNext;
      if (stb.loadWr) loadQ <= wrData;
    end
  end
endmodule

// File: rtl/tmr_dual.sv
module tmr_dual
  import tmr_pkg::*;
#(
  parameter int NUM_TIMERS = 2,
  parameter int DATA_W = 32,
  localparam int TSEL_W = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1,
  localparam int ADDR_W = TSEL_W + 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              irq
);
  chanStrobe_t       stb [NUM_TIMERS];
  regSel_e           regSel;
  logic [TSEL_W-1:0] chanSel;
  logic              chanValid;

  logic [NUM_TIMERS-1:0][CTRL_BITS-1:0] chanCtrl;
  logic [NUM_TIMERS-1:0][DATA_W-1:0]    chanLoad;
  logic [NUM_TIMERS-1:0][DATA_W-1:0]    chanCount;

  tmr_decode #(
    .NUM_TIMERS(NUM_TIMERS), .DATA_W(DATA_W), .TSEL_W(TSEL_W), .ADDR_W(ADDR_W)
  ) u_decode (
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .stb(stb), .regSel(regSel), .chanSel(chanSel), .chanValid(chanValid)
  );

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_chan
    tmr_chan #(.DATA_W(DATA_W)) u_chan (
      .clk(clk), .rstN(rstN), .stb(stb[i]), .wrData(busWrData),
      .ctrlQ(chanCtrl[i]), .loadQ(chanLoad[i]), .countQ(chanCount[i])
    );
  end

  always_comb begin
    busRdData = '0;
    if (chanValid) begin
      case (regSel)
        SEL_CTRL:  busRdData[CTRL_BITS-1:0] = chanCtrl[chanSel];
        SEL_LOAD:  busRdData = chanLoad[chanSel];
        SEL_COUNT: busRdData = chanCount[chanSel];
        default:   busRdData = '0;
      endcase
    end
  end

  always_comb begin
    irq = 1'b0;
    for (int i = 0; i < NUM_TIMERS; i++)
      irq = irq | (chanCtrl[i][B_PEND] & chanCtrl[i][B_IE]);
  end
endmodule

// File: rtl/tmr_dual_chk.sv
module tmr_dual_chk
  import tmr_pkg::*;
#(
  parameter int NUM_TIMERS = 2,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [DATA_W-1:0] busWrData,
  input logic [DATA_W-1:0] busRdData,
  input logic              irq,
  input logic [NUM_TIMERS-1:0][CTRL_BITS-1:0] chanCtrl,
  input logic [NUM_TIMERS-1:0][DATA_W-1:0]    chanLoad,
  input logic [NUM_TIMERS-1:0][DATA_W-1:0]    chanCount
);
  logic ctrlAddr;
  assign ctrlAddr = (busAddr[3:2] == 2'd0) && (int'(busAddr[ADDR_W-1:4]) < NUM_TIMERS);

  assert_hibits_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctrlAddr |-> busRdData[DATA_W-1:CTRL_BITS] == '0);

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_chk
    logic wrCtl;
    assign wrCtl = busWrEn && ctrlAddr && (int'(busAddr[ADDR_W-1:4]) == i);

    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
      chanCtrl[i][B_PEND] && !(wrCtl && busWrData[B_PEND]) |=> chanCtrl[i][B_PEND]);

    assert_w1c_R4: assert property (@(posedge clk) disable iff (!rstN)
      wrCtl && busWrData[B_PEND] && !chanCtrl[i][B_RUN] |=> !chanCtrl[i][B_PEND]);

    assert_load_R5: assert property (@(posedge clk) disable iff (!rstN)
      chanCtrl[i][B_LOAD] |=> chanCount[i] == $past(chanLoad[i]));

    assert_frozen_R6: assert property (@(posedge clk) disable iff (!rstN)
      !chanCtrl[i][B_LOAD] && !chanCtrl[i][B_RUN] |=> $stable(chanCount[i]));

    assert_down_R6: assert property (@(posedge clk) disable iff (!rstN)
      chanCtrl[i][B_RUN] && !chanCtrl[i][B_LOAD] && chanCtrl[i][B_DOWN] && chanCount[i] != '0
      |=> chanCount[i] == $past(chanCount[i]) - 1'b1);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
      !busWrEn && chanCtrl[i][B_RUN] && !chanCtrl[i][B_LOAD] && !chanCtrl[i][B_AUTO]
      && chanCtrl[i][B_DOWN] && chanCount[i] == '0
      |=> !chanCtrl[i][B_RUN] && chanCtrl[i][B_PEND] && chanCount[i] == '0);

    assert_irq_R10: assert property (@(posedge clk) disable iff (!rstN)
      chanCtrl[i][B_PEND] && chanCtrl[i][B_IE] |-> irq);

    assert_enall_R11: assert property (@(posedge clk) disable iff (!rstN)
      busWrEn && ctrlAddr && busWrData[B_ALL] |=> chanCtrl[i][B_RUN]);
  end
endmodule

bind tmr_dual tmr_dual_chk #(
  .NUM_TIMERS(NUM_TIMERS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busWrData(busWrData), .busRdData(busRdData), .irq(irq),
  .chanCtrl(chanCtrl), .chanLoad(chanLoad), .chanCount(chanCount)
);

// File: tb/tmr_dual_tb.sv
module tmr_dual_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [10:0] mCtrl [2];
  logic [31:0] mLoad [2];
  logic [31:0] mCnt  [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_dual u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .irq(irq)
  );

  function automatic logic [31:0] expRead(logic [4:0] a);
    case (a[3:2])
      2'd0: return {21'd0, mCtrl[a[4]]};
      2'd1: return mLoad[a[4]];
      2'd2: return mCnt[a[4]];
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic expIrq();
    return (mCtrl[0][8] & mCtrl[0][6]) | (mCtrl[1][8] & mCtrl[1][6]);
  endfunction

  task automatic modelReset();
    for (int c = 0; c < 2; c++) begin
      mCtrl[c] = '0; mLoad[c] = '0; mCnt[c] = '0;
    end
  endtask

  task automatic modelStep(bit wr, logic [4:0] a, logic [31:0] d);
    bit enAll = wr && a[3:2] == 2'd0 && d[10];
    for (int c = 0; c < 2; c++) begin
      logic [10:0] oc = mCtrl[c];
      logic [10:0] nc = oc;
      bit term = oc[1] ? (mCnt[c] == 32'd0) : (mCnt[c] == 32'hFFFF_FFFF);
      bit exp = !oc[5] && oc[7] && term;
      bit ctlW = wr && a[4] == c[0] && a[3:2] == 2'd0;
      if (oc[5]) mCnt[c] = mLoad[c];
      else if (oc[7]) begin
        if (term) begin
          if (oc[4]) mCnt[c] = mLoad[c];
        end else mCnt[c] = oc[1] ? mCnt[c] - 1 : mCnt[c] + 1;
      end
      if (ctlW) begin
        nc = d[10:0];
        nc[8] = oc[8] & ~d[8];
      end else if (exp && !oc[4]) nc[7] = 1'b0;
      if (exp) nc[8] = 1'b1;
      if (enAll) nc[7] = 1'b1;
      mCtrl[c] = nc;
      if (wr && a[4] == c[0] && a[3:2] == 2'd1) mLoad[c] = d;
    end
  endtask

  task automatic tick(bit wr, logic [4:0] a, logic [31:0] d, bit chk, string tag);
    @(negedge clk);
    busWrEn = wr; busAddr = a; busWrData = d;
    #1;
    if (chk) begin
      checks++;
      if (busRdData !== expRead(a)) begin
        fails++;
        $display("FAIL %s read @%h actual %h expected %h", tag, a, busRdData, expRead(a));
      end
      checks++;
      if (irq !== expIrq()) begin
        fails++;
        $display("FAIL R10 (%s) irq actual %b expected %b", tag, irq, expIrq());
      end
    end
    @(posedge clk);
    modelStep(wr, a, d);
  endtask

  task automatic rd(logic [4:0] a, string tag);
    tick(1'b0, a, 32'd0, 1'b1, tag);
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d, string tag);
    tick(1'b1, a, d, 1'b1, tag);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset state of every register
    for (int a = 0; a < 32; a += 4) rd(5'(a), "R1");

    // R3: stored bits read back, upper bits zero
    wr(5'h00, 32'h0000_020D, "R3");
    rd(5'h00, "R3");
    wr(5'h10, 32'hFFFF_F409, "R3");
    rd(5'h10, "R3");
    wr(5'h10, 32'h0, "R3");

    // R2: map, counter writes ignored, selector 3 is zero
    wr(5'h04, 32'd5, "R2");
    wr(5'h08, 32'h1234_5678, "R2");
    rd(5'h08, "R2"); rd(5'h04, "R2"); rd(5'h0C, "R2"); rd(5'h1C, "R2");

    // R5: load bit copies reload value continuously
    wr(5'h00, 32'h22, "R5");
    rd(5'h08, "R5");
    wr(5'h04, 32'd4, "R5");
    rd(5'h08, "R5"); rd(5'h08, "R5");

    // R7 / R10: periodic down count with interrupt
    wr(5'h00, 32'hD2, "R7");
    for (int k = 0; k < 12; k++) rd(5'h08, "R7");
    rd(5'h00, "R7");
    // R4: write 0 to pending keeps it, write-back acknowledges
    wr(5'h00, 32'hD2, "R4");
    rd(5'h00, "R4");
    wr(5'h00, expRead(5'h00), "R4");
    rd(5'h00, "R4");

    // R6: stop keeps the value
    wr(5'h00, 32'h52, "R6");
    rd(5'h08, "R6"); rd(5'h08, "R6"); rd(5'h08, "R6");

    // R12: reload 0 expires every clock; clear in same clock keeps flag
    wr(5'h04, 32'd0, "R12");
    wr(5'h00, 32'h22, "R12");
    wr(5'h00, 32'hD2, "R12");
    rd(5'h08, "R12");
    wr(5'h00, 32'h1D2, "R12");
    rd(5'h00, "R12");

    // R8: up count wraps through all-ones with reload
    wr(5'h14, 32'hFFFF_FFFD, "R8");
    wr(5'h10, 32'h30, "R8");
    wr(5'h10, 32'h90, "R8");
    for (int k = 0; k < 6; k++) rd(5'h18, "R8");
    wr(5'h14, 32'd0, "R8");
    wr(5'h10, 32'h130, "R8");
    wr(5'h10, 32'h90, "R8");
    rd(5'h18, "R8");

    // R9: hold on expiry, run bit drops
    wr(5'h00, 32'h0, "R9");
    wr(5'h04, 32'd2, "R9");
    wr(5'h00, 32'h22, "R9");
    wr(5'h00, 32'h82, "R9");
    for (int k = 0; k < 5; k++) rd(5'h08, "R9");
    rd(5'h00, "R9");

    // R11: enable-all from channel 1 starts channel 0 as well
    wr(5'h00, 32'h102, "R11");
    wr(5'h10, 32'h400, "R11");
    rd(5'h00, "R11"); rd(5'h10, "R11"); rd(5'h08, "R11");

    // R13: capture/generate/pwm bits leave counting unchanged
    wr(5'h04, 32'd3, "R13");
    wr(5'h00, 32'h22F, "R13");
    wr(5'h00, 32'h39F, "R13");
    for (int k = 0; k < 8; k++) rd(5'h08, "R13");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int unsigned r = $urandom_range(0, 99);
      logic [4:0] a = 5'({$urandom_range(0, 1), 2'($urandom_range(0, 3)), 2'b00});
      logic [31:0] d;
      if (r < 25) begin
        if (a[3:2] == 2'd1) begin
          case ($urandom_range(0, 3))
            0: d = 32'd0;
            1: d = $urandom_range(1, 6);
            2: d = 32'hFFFF_FFFF - $urandom_range(0, 5);
            default: d = $urandom;
          endcase
        end else begin
          d = $urandom & 32'hFFFF_FFDF;
          if ($urandom_range(0, 7) == 0) d[5] = 1'b1;
          if ($urandom_range(0, 3) != 0) d[10] = 1'b0;
        end
        wr(a, d, "R6");
      end else begin
        rd(a, "R6");
      end
    end

    finishRun();
  end
endmodule